// File: doc/BRIEF.md
# Sub-addressed Video Control Register Bank with Two-Wire Write Port

This block is a write-only slave on a two-wire serial bus (I2C) that holds sixteen byte-wide control registers for a video path. The serial clock and data lines are sampled with the system clock through a two-stage synchronizer. START and STOP conditions are decoded from data edges while the clock is high. A write transaction is a device-address byte, then a sub-address byte, then data bytes. The slave acknowledges a byte by pulling the data line low during the ninth clock, which appears as an output enable.

There are two update modes, chosen by a bit in one of the registers. In immediate mode every data byte lands in its register straight away, and the sub-address pointer advances after each byte, wrapping from 0x0F to 0x00. In buffered mode the slave takes one data byte per transaction and keeps it in a shadow copy. It copies that byte into the live register on the next rising edge of the vertical-blanking input, and refuses further data until the copy has happened. All sixteen live registers are presented in parallel.

The parser states are IDLE, ADDR, ADDR_ACK, SUB, SUB_ACK, DATA, DATA_ACK and SKIP. START moves any state to ADDR, and STOP moves any state to IDLE. After eight bits, ADDR goes to ADDR_ACK on a matching write address and otherwise to SKIP. After eight bits, SUB goes to SUB_ACK for a sub-address in range and otherwise to SKIP. After eight bits, DATA goes to DATA_ACK when the byte is accepted and otherwise to SKIP. Each ACK state returns to the next receive state (SUB, DATA, DATA) on the falling clock edge that ends the ninth bit. IDLE and SKIP stay where they are until a START or STOP arrives.

Top module: `vidreg_i2c_bank`

## Requirements
- R1: After reset, all sixteen registers read zero, sda_oe_o is low and the bank is in immediate mode.
- R2: The slave acknowledges the address byte only when it equals {7'h44, 1'b0}. Any other address byte, including a read of 7'h44, gets no acknowledge and changes no register.
- R3: A sub-address byte from 0x00 to 0x0F is acknowledged. A sub-address of 0x10 or above is not acknowledged, and no data byte of that transaction is acknowledged or written.
- R4: In immediate mode each acknowledged data byte appears on regs_o (register k at bits 8k+7..8k) by the end of its acknowledge. Successive bytes go to successive sub-addresses, and the pointer wraps from 0x0F to 0x00.
- R5: Sub-addresses 0x0B, 0x0E and 0x0F are acknowledged and use a pointer slot, but their outputs stay zero.
- R6: Bit 0 of register 0x0D selects the mode: 0 means immediate, 1 means buffered. Leaving buffered mode only takes effect after a vertical-blanking transfer.
- R7: In buffered mode the first data byte of a transaction is acknowledged and kept aside, and regs_o does not change. Every later data byte in the same transaction is not acknowledged.
- R8: While a buffered byte waits for transfer, any further data byte is not acknowledged and is stored nowhere.
- R9: A rising edge on vblank_i copies the waiting byte to its live register and clears the wait. A rising edge with nothing waiting changes nothing.
- R10: A vblank_i rising edge in the same cycle as a buffered byte is accepted does not transfer that byte. The byte is kept, and the next rising edge transfers it.
- R11: A STOP returns the parser to idle and releases the data line, so a byte sent without a new START is not acknowledged. A repeated START restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| vblank_i | input | 1 | Vertical-blanking pulse, synchronous to clk |
| sda_oe_o | output | 1 | When high, the data line is pulled low (acknowledge) |
| regs_o | output | 128 | Live registers; register k occupies bits 8k+7..8k |

## Verification
Two functions can fall in the same clock cycle: acceptance of a buffered data byte, and the transfer triggered by a vertical-blanking rising edge. The bench places the vblank_i rise exactly on the cycle in which the synchronized falling clock edge completes the eighth data bit. It then checks three things at the ports: the target register keeps its old value, a following data byte is refused because a byte is still waiting, and the next vblank_i rise delivers the byte.

// File: rtl/vidreg_pkg.sv
package vidreg_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } prs_state_e;
endpackage

// File: rtl/vidreg_line_sync.sv
module vidreg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/vidreg_i2c_parser.sv
module vidreg_i2c_parser
    import vidreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h44,
    parameter int         NREG     = 16,
    parameter int         AW       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              buf_mode,
    input  logic              pending,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [BYTE_W-1:0] NREG_B = BYTE_W'(NREG);

    prs_state_e        state_q, state_d;
    logic [3:0]        cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [AW-1:0]     ptr_q;
    logic              first_q;
    logic              oe_q;
    logic              rcv;
    logic              byte_done;

    assign rcv       = (state_q == ST_ADDR) || (state_q == ST_SUB) || (state_q == ST_DATA);
    assign byte_done = rcv && scl_fall && (cnt_q == 4'd8);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and write strobe
    always_comb begin
        state_d = state_q;
        wr_en   = 1'b0;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: state_d = state_q;
                ST_ADDR: if (byte_done)
                    state_d = (shreg_q == {DEV_ADDR, 1'b0}) ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall) state_d = ST_SUB;
                ST_SUB: if (byte_done)
                    state_d = (shreg_q < NREG_B) ? ST_SUB_ACK : ST_SKIP;
                ST_SUB_ACK: if (scl_fall) state_d = ST_DATA;
                ST_DATA: if (byte_done) begin
                    if (!buf_mode || (first_q && !pending)) begin
                        state_d = ST_DATA_ACK;
                        wr_en   = 1'b1;
                    end else begin
                        state_d = ST_SKIP;
                    end
                end
                ST_DATA_ACK: if (scl_fall) state_d = ST_DATA;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            ptr_q   <= '0;
            first_q <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            oe_q <= (state_d == ST_ADDR_ACK) || (state_d == ST_SUB_ACK) ||
                    (state_d == ST_DATA_ACK);
            if (start_det || stop_det || byte_done) begin
                cnt_q <= '0;
            end else if (rcv && scl_rise) begin
                shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
                cnt_q   <= cnt_q + 4'd1;
            end
            if (state_q == ST_SUB && byte_done && !start_det && !stop_det) begin
                ptr_q   <= shreg_q[AW-1:0];
                first_q <= 1'b1;
            end else if (wr_en) begin
                ptr_q   <= ptr_q + 1'b1;
                first_q <= 1'b0;
            end
        end
    end

    assign sda_oe  = oe_q;
    assign wr_addr = ptr_q;
    assign wr_data = shreg_q;
endmodule

// File: rtl/vidreg_store.sv
module vidreg_store
    import vidreg_pkg::*;
#(
    parameter int              NREG     = 16,
    parameter int              AW       = 4,
    parameter logic [NREG-1:0] RSV_MASK = 16'hC800,
    parameter int              CTRL_IDX = 13,
    parameter int              BUF_BIT  = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic                   vblank_i,
    output logic [NREG*BYTE_W-1:0] live_flat,
    output logic                   buf_mode,
    output logic                   pending,
    output logic                   vb_rise
);
    logic [BYTE_W-1:0] live_q   [NREG];
    logic [BYTE_W-1:0] shadow_q [NREG];
    logic [NREG-1:0]   dirty_q;
    logic              pending_q;
    logic              vb_q;
    logic              rsv_hit;

    assign buf_mode = live_q[CTRL_IDX][BUF_BIT];
    assign vb_rise  = vblank_i & ~vb_q;
    assign rsv_hit  = RSV_MASK[wr_addr];
    assign pending  = pending_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                live_q[i]   <= '0;
                shadow_q[i] <= '0;
            end
            dirty_q   <= '0;
            pending_q <= 1'b0;
            vb_q      <= 1'b0;
        end else begin
            vb_q <= vblank_i;
            if (vb_rise && pending_q) begin
                for (int i = 0; i < NREG; i++)
                    if (dirty_q[i]) live_q[i] <= shadow_q[i];
                dirty_q   <= '0;
                pending_q <= 1'b0;
            end
            if (wr_en) begin
                if (buf_mode) begin
                    pending_q <= 1'b1;
                    if (!rsv_hit) begin
                        shadow_q[wr_addr] <= wr_data;
                        dirty_q[wr_addr]  <= 1'b1;
                    end
                end else if (!rsv_hit) begin
                    live_q[wr_addr] <= wr_data;
                end
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign live_flat[g*BYTE_W +: BYTE_W] = live_q[g];
    end
endmodule

// File: rtl/vidreg_i2c_bank.sv
module vidreg_i2c_bank
    import vidreg_pkg::*;
#(
    parameter logic [6:0]      DEV_ADDR    = 7'h44,
    parameter int              NREG        = 16,
    parameter int              SYNC_STAGES = 2,
    parameter logic [NREG-1:0] RSV_MASK    = 16'hC800,
    parameter int              CTRL_IDX    = 13,
    parameter int              BUF_BIT     = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic                   vblank_i,
    output logic                   sda_oe_o,
    output logic [NREG*BYTE_W-1:0] regs_o
);
    localparam int AW = $clog2(NREG);

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              buf_mode, pending, vb_rise, wr_en;
    logic [AW-1:0]     wr_addr;
    logic [BYTE_W-1:0] wr_data;

    vidreg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    vidreg_i2c_parser #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .AW(AW)) u_parser (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .buf_mode(buf_mode), .pending(pending), .sda_oe(sda_oe_o),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    vidreg_store #(.NREG(NREG), .AW(AW), .RSV_MASK(RSV_MASK),
                   .CTRL_IDX(CTRL_IDX), .BUF_BIT(BUF_BIT)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .vblank_i(vblank_i), .live_flat(regs_o),
        .buf_mode(buf_mode), .pending(pending), .vb_rise(vb_rise)
    );
endmodule

// File: rtl/vidreg_i2c_chk.sv
module vidreg_i2c_chk #(
    parameter int              NREG     = 16,
    parameter logic [NREG-1:0] RSV_MASK = 16'hC800
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NREG*8-1:0] regs,
    input logic              sda_oe,
    input logic              buf_mode,
    input logic              pending,
    input logic              vb_rise,
    input logic              wr_en,
    input logic              stop_det
);
    for (genvar g = 0; g < NREG; g++) begin : g_rsv
        if (RSV_MASK[g]) begin : g_on
            assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
                regs[g*8 +: 8] == 8'h00);
        end
    end

    assert_live_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_mode && !vb_rise) |=> $stable(regs));

    assert_no_write_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && buf_mode) |-> !pending);

    assert_pending_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vb_rise && pending) |=> !pending);

    assert_release_on_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

bind vidreg_i2c_bank vidreg_i2c_chk #(.NREG(NREG), .RSV_MASK(RSV_MASK)) chk_i (
    .clk(clk), .rst_n(rst_n), .regs(regs_o), .sda_oe(sda_oe_o),
    .buf_mode(buf_mode), .pending(pending), .vb_rise(vb_rise),
    .wr_en(wr_en), .stop_det(stop_det)
);

// File: tb/vidreg_i2c_bank_tb.sv
module vidreg_i2c_bank_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl = 1'b1;
    logic         sda_drv = 1'b1;
    logic         vblank = 1'b0;
    logic         sda_oe;
    logic [127:0] regs;
    logic         sda_line;
    int           errors = 0;
    int           checks = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    vidreg_i2c_bank dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .vblank_i(vblank), .sda_oe_o(sda_oe), .regs_o(regs)
    );

    // {sub, data, expected sub ack, register to inspect, expected value}
    localparam logic [28:0] VEC [8] = '{
        {8'h00, 8'h5A, 1'b1, 4'h0, 8'h5A},
        {8'h07, 8'hC3, 1'b1, 4'h7, 8'hC3},
        {8'h0B, 8'hFF, 1'b1, 4'hB, 8'h00},
        {8'h0F, 8'h11, 1'b1, 4'hF, 8'h00},
        {8'h10, 8'h77, 1'b0, 4'h0, 8'h5A},
        {8'hFF, 8'h22, 1'b0, 4'h7, 8'hC3},
        {8'h0D, 8'hFE, 1'b1, 4'hD, 8'hFE},
        {8'h0C, 8'h81, 1'b1, 4'hC, 8'h81}
    };

    function automatic logic [7:0] rg(input int i);
        return regs[i*8 +: 8];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_drv = 1'b1; scl = 1'b1; waitn(4);
        sda_drv = 1'b0; waitn(4);
        scl = 1'b0; waitn(4);
    endtask

    task automatic bus_stop;
        sda_drv = 1'b0; waitn(4);
        scl = 1'b1; waitn(4);
        sda_drv = 1'b1; waitn(8);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit vb_hit, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; waitn(4);
            scl = 1'b1; waitn(8);
            scl = 1'b0;
            if (i == 0 && vb_hit) begin
                waitn(2);
                vblank = 1'b1;
                waitn(2);
            end else begin
                waitn(4);
            end
        end
        sda_drv = 1'b1; waitn(4);
        scl = 1'b1; waitn(4);
        ack = sda_oe;
        waitn(4);
        scl = 1'b0; waitn(4);
    endtask

    task automatic wr_txn(input logic [7:0] sub, input int n, input logic [7:0] d0,
                          input logic [7:0] d1, input logic [7:0] d2, input bit vb_hit,
                          output bit a_dev, output bit a_sub, output logic [2:0] a_dat);
        bit a;
        logic [7:0] d;
        a_dat = 3'b000;
        bus_start();
        send_byte(8'h88, 1'b0, a_dev);
        send_byte(sub, 1'b0, a_sub);
        for (int k = 0; k < n; k++) begin
            d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
            send_byte(d, vb_hit && (k == 0), a);
            a_dat[k] = a;
        end
        bus_stop();
    endtask

    task automatic vb_pulse;
        vblank = 1'b1; waitn(3);
        vblank = 1'b0; waitn(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ad, as_, a1;
        logic [2:0] adt;
        waitn(4);
        rst_n = 1'b1;
        waitn(4);
        chk("R1 regs zero", {31'd0, regs == 128'd0}, 32'd1);
        chk("R1 sda_oe low", {31'd0, sda_oe}, 32'd0);

        // table walk: single-byte writes in immediate mode
        for (int v = 0; v < 8; v++) begin
            wr_txn(VEC[v][28:21], 1, VEC[v][20:13], 8'h00, 8'h00, 1'b0, ad, as_, adt);
            chk("R2 dev ack", {31'd0, ad}, 32'd1);
            chk("R3 sub ack", {31'd0, as_}, {31'd0, VEC[v][12]});
            chk("R3 data ack", {31'd0, adt[0]}, {31'd0, VEC[v][12]});
            chk("R4/R5 table reg", {24'd0, rg(int'(VEC[v][11:8]))}, {24'd0, VEC[v][7:0]});
        end

        // R2: foreign address and read direction
        bus_start(); send_byte(8'h8A, 1'b0, a1); bus_stop();
        chk("R2 foreign addr nack", {31'd0, a1}, 32'd0);
        bus_start(); send_byte(8'h89, 1'b0, a1); bus_stop();
        chk("R2 read dir nack", {31'd0, a1}, 32'd0);
        chk("R2 no change", {24'd0, rg(0)}, 32'h5A);

        // R4: auto-increment run
        wr_txn(8'h01, 3, 8'h11, 8'h22, 8'h33, 1'b0, ad, as_, adt);
        chk("R4 run acks", {29'd0, adt}, 32'd7);
        chk("R4 reg1", {24'd0, rg(1)}, 32'h11);
        chk("R4 reg2", {24'd0, rg(2)}, 32'h22);
        chk("R4 reg3", {24'd0, rg(3)}, 32'h33);

        // R4/R5: wrap through reserved slots
        wr_txn(8'h0E, 3, 8'hA1, 8'hA2, 8'hA3, 1'b0, ad, as_, adt);
        chk("R5 reserved acks", {29'd0, adt}, 32'd7);
        chk("R5 regE zero", {24'd0, rg(14)}, 32'h0);
        chk("R5 regF zero", {24'd0, rg(15)}, 32'h0);
        chk("R4 wrap reg0", {24'd0, rg(0)}, 32'hA3);

        // R11: byte after STOP without START; repeated START
        send_byte(8'h88, 1'b0, a1); bus_stop();
        chk("R11 no start nack", {31'd0, a1}, 32'd0);
        bus_start(); send_byte(8'h88, 1'b0, a1);
        bus_start(); send_byte(8'h88, 1'b0, ad);
        send_byte(8'h04, 1'b0, as_); send_byte(8'h3C, 1'b0, a1); bus_stop();
        chk("R11 restart ack", {30'd0, ad, a1}, 32'd3);
        chk("R11 restart reg4", {24'd0, rg(4)}, 32'h3C);

        // R6: enter buffered mode
        wr_txn(8'h0D, 1, 8'h01, 8'h00, 8'h00, 1'b0, ad, as_, adt);
        chk("R6 ctrl written", {24'd0, rg(13)}, 32'h01);

        // R7: one byte kept aside, rest refused
        wr_txn(8'h02, 2, 8'h55, 8'h66, 8'h00, 1'b0, ad, as_, adt);
        chk("R7 acks", {30'd0, adt[1:0]}, 32'd1);
        chk("R7 reg2 held", {24'd0, rg(2)}, 32'h22);
        chk("R7 reg3 untouched", {24'd0, rg(3)}, 32'h33);

        // R8: refused while waiting
        wr_txn(8'h03, 1, 8'h99, 8'h00, 8'h00, 1'b0, ad, as_, adt);
        chk("R8 sub ack", {31'd0, as_}, 32'd1);
        chk("R8 data nack", {31'd0, adt[0]}, 32'd0);

        // R9: transfer
        vb_pulse();
        chk("R9 reg2 moved", {24'd0, rg(2)}, 32'h55);
        chk("R9 reg3 kept", {24'd0, rg(3)}, 32'h33);
        vb_pulse();
        chk("R9 idle edge", {24'd0, rg(2)}, 32'h55);

        // R10: vblank edge in the accept cycle
        wr_txn(8'h05, 1, 8'h77, 8'h00, 8'h00, 1'b1, ad, as_, adt);
        vblank = 1'b0; waitn(3);
        chk("R10 data ack", {31'd0, adt[0]}, 32'd1);
        chk("R10 reg5 not moved", {24'd0, rg(5)}, 32'h00);
        wr_txn(8'h06, 1, 8'h12, 8'h00, 8'h00, 1'b0, ad, as_, adt);
        chk("R10 still waiting", {31'd0, adt[0]}, 32'd0);
        vb_pulse();
        chk("R10 reg5 moved", {24'd0, rg(5)}, 32'h77);
        chk("R10 reg6 empty", {24'd0, rg(6)}, 32'h00);

        // R6: leave buffered mode
        wr_txn(8'h0D, 1, 8'h00, 8'h00, 8'h00, 1'b0, ad, as_, adt);
        chk("R6 ctrl held", {24'd0, rg(13)}, 32'h01);
        vb_pulse();
        chk("R6 ctrl cleared", {24'd0, rg(13)}, 32'h00);
        wr_txn(8'h08, 2, 8'h05, 8'h06, 8'h00, 1'b0, ad, as_, adt);
        chk("R6 immediate acks", {30'd0, adt[1:0]}, 32'd3);
        chk("R6 reg8", {24'd0, rg(8)}, 32'h05);
        chk("R6 reg9", {24'd0, rg(9)}, 32'h06);
        vb_pulse();
        chk("R9 edge in immediate", {24'd0, rg(8)}, 32'h05);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule